// File: doc/BRIEF.md
# Second-Level Register Reference-Count Allocator

This block decides which entries of a second-level register file can be handed out again. Each register has three reference counters, one per structure that can name it: the operations in flight in the reorder buffer, the speculative rename map and the retirement rename map. A register counts as free only when all three of its counters are zero. A combinational search returns the lowest-numbered free register to a request/grant port.

The counters change through event ports. A rename-update port reports that a slot of either map was overwritten. It carries the register the old mapping held and the one the new mapping holds, and each side can be absent. The push and pop ports have several lanes each. Every valid lane adds or removes one reorder-buffer reference to the register it names. A flush wipes every reorder-buffer counter and leaves the two map counters alone. An event that would take a counter below zero or above its limit is rejected and sets a sticky error output.

Top module: `l2_refcount_alloc`

## Requirements
- R1: After reset every counter is zero and `err` is 0. A request is therefore granted with index 0.
- R2: `alloc_gnt` is 1 exactly when `alloc_req` is 1 and some register has all three counters at zero. `alloc_idx` is then the lowest such register. Whenever `alloc_gnt` is 0, `alloc_idx` is 0.
- R3: A rename update (`ren_vld`=1) acts only on the map that `ren_sel` selects (0 = speculative, 1 = retirement). It subtracts one from the count of `ren_old_idx` when `ren_old_vld` is 1 and adds one to the count of `ren_new_idx` when `ren_new_vld` is 1. The change is visible from the next cycle on.
- R4: A rename update whose old and new register are the same leaves that count unchanged and raises no error, even when the count is zero.
- R5: Each valid push lane adds one to the reorder-buffer count of the register it names. Several lanes naming the same register each add one.
- R6: Each valid pop lane subtracts one from the reorder-buffer count of the register it names.
- R7: `flush` sets every reorder-buffer count to zero and discards any push or pop in the same cycle. Both map counts keep their values.
- R8: An update that would make a counter negative sets `err` and leaves that counter unchanged.
- R9: An update that would take a map counter above NUM_REGS, or a reorder-buffer counter above ROB_DEPTH, sets `err` and leaves that counter unchanged.
- R10: Once `err` is set it stays 1 until reset.
- R11: Increments and decrements that reach the same counter in the same cycle are netted, so no event is lost. Example: a push and a pop of a register whose count is zero leave it at zero with no error.
- R12: The grant outputs depend only on counter state committed at earlier clock edges. An event on the inputs does not change them before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_req | input | 1 | Request for a free register |
| alloc_gnt | output | 1 | A free register is offered |
| alloc_idx | output | IW | Lowest free register, 0 when no grant |
| ren_vld | input | 1 | Rename-map slot overwritten this cycle |
| ren_sel | input | 1 | Map select: 0 speculative, 1 retirement |
| ren_old_vld | input | 1 | Old mapping named a register |
| ren_old_idx | input | IW | Register released by the old mapping |
| ren_new_vld | input | 1 | New mapping names a register |
| ren_new_idx | input | IW | Register acquired by the new mapping |
| push_vld | input | LANES | Per-lane push of an operation naming a register |
| push_idx | input | LANES*IW | Per-lane register index of pushes, lane i at bits [i*IW +: IW] |
| pop_vld | input | LANES | Per-lane retirement of an operation naming a register |
| pop_idx | input | LANES*IW | Per-lane register index of pops, lane i at bits [i*IW +: IW] |
| flush | input | 1 | Clear all reorder-buffer counts |
| err | output | 1 | Sticky underflow/overflow flag |

## Verification
The bench targets four corner cases, each of which a wrong design would show at the ports:
- A replacement whose old and new register are the same. A design that decrements before it increments would raise a false underflow.
- A push and a pop of one register in the same cycle. A design that kept only one of the two events would leave that register stuck busy.
- A flush that arrives together with a push, run against a live speculative mapping. A design that cleared every table, or that let the push through, would hand out the wrong lowest index.
- Counters taken past their limits and below zero. A design that wrapped or saturated the bad update, instead of holding the counter, would free a register early or never free it after the matching releases.

// File: rtl/l2rc_pkg.sv
package l2rc_pkg;
  typedef enum logic {
    TBL_SPEC = 1'b0,
    TBL_RET  = 1'b1
  } tbl_sel_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/l2rc_bank.sv
module l2rc_bank #(
  parameter int NREG  = 8,
  parameter int LIMIT = 16,
  parameter int CW    = 5,
  parameter int NI    = 1,
  parameter int ND    = 1,
  localparam int IW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NI-1:0]      inc_vld,
  input  logic [NI*IW-1:0]   inc_idx,
  input  logic [ND-1:0]      dec_vld,
  input  logic [ND*IW-1:0]   dec_idx,
  output logic [NREG*CW-1:0] cnt_o,
  output logic [NREG-1:0]    zero_o,
  output logic               err_o
);
  logic [NREG-1:0] bad_v;

  for (genvar g = 0; g < NREG; g++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          cnt_en;
    logic          bad;

    always_comb begin
      int n_up;
      int n_dn;
      int nxt;
      n_up = 0;
      n_dn = 0;
      for (int i = 0; i < NI; i++) begin
        if (inc_vld[i] && (inc_idx[i*IW +: IW] == IW'(g))) n_up++;
      end
      for (int i = 0; i < ND; i++) begin
        if (dec_vld[i] && (dec_idx[i*IW +: IW] == IW'(g))) n_dn++;
      end
      nxt   = int'(cnt_q) + n_up - n_dn;
      cnt_d = cnt_q;
      bad   = 1'b0;
      if (clr) begin
        cnt_d = '0;
      end else if ((nxt < 0) || (nxt > LIMIT)) begin
        bad = 1'b1;
      end else begin
        cnt_d = CW'(nxt);
      end
      cnt_en = (cnt_d != cnt_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt_o[g*CW +: CW] = cnt_q;
    assign zero_o[g]         = (cnt_q == '0);
    assign bad_v[g]          = bad;
  end

  assign err_o = |bad_v;
endmodule

// File: rtl/l2rc_pick.sv
module l2rc_pick #(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] avail,
  output logic            found,
  output logic [IW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (avail[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/l2_refcount_alloc.sv
module l2_refcount_alloc #(
  parameter int NUM_REGS  = 8,
  parameter int RT_SLOTS  = 16,
  parameter int ROB_DEPTH = 16,
  parameter int LANES     = 2,
  localparam int IW       = $clog2(NUM_REGS),
  localparam int RT_MAX   = (RT_SLOTS > NUM_REGS) ? RT_SLOTS : NUM_REGS,
  localparam int RT_CW    = l2rc_pkg::cnt_width(RT_MAX),
  localparam int ROB_CW   = l2rc_pkg::cnt_width(ROB_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_req,
  output logic                alloc_gnt,
  output logic [IW-1:0]       alloc_idx,
  input  logic                ren_vld,
  input  logic                ren_sel,
  input  logic                ren_old_vld,
  input  logic [IW-1:0]       ren_old_idx,
  input  logic                ren_new_vld,
  input  logic [IW-1:0]       ren_new_idx,
  input  logic [LANES-1:0]    push_vld,
  input  logic [LANES*IW-1:0] push_idx,
  input  logic [LANES-1:0]    pop_vld,
  input  logic [LANES*IW-1:0] pop_idx,
  input  logic                flush,
  output logic                err
);
  import l2rc_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // steering of the rename event to one of the two map banks
  logic spec_hit, ret_hit;
  assign spec_hit = ren_vld && (ren_sel == TBL_SPEC);
  assign ret_hit  = ren_vld && (ren_sel == TBL_RET);

  logic [NUM_REGS*ROB_CW-1:0] rob_cnt;
  logic [NUM_REGS*RT_CW-1:0]  spec_cnt, ret_cnt;
  logic [NUM_REGS-1:0]        rob_zero, spec_zero, ret_zero;
  logic                       rob_bad, spec_bad, ret_bad;

  l2rc_bank #(.NREG(NUM_REGS), .LIMIT(ROB_DEPTH), .CW(ROB_CW),
              .NI(LANES), .ND(LANES)) u_rob (
    .clk(clk), .rst_n(rst_ni), .clr(flush),
    .inc_vld(push_vld), .inc_idx(push_idx),
    .dec_vld(pop_vld),  .dec_idx(pop_idx),
    .cnt_o(rob_cnt), .zero_o(rob_zero), .err_o(rob_bad)
  );

  l2rc_bank #(.NREG(NUM_REGS), .LIMIT(NUM_REGS), .CW(RT_CW),
              .NI(1), .ND(1)) u_spec (
    .clk(clk), .rst_n(rst_ni), .clr(1'b0),
    .inc_vld(spec_hit && ren_new_vld), .inc_idx(ren_new_idx),
    .dec_vld(spec_hit && ren_old_vld), .dec_idx(ren_old_idx),
    .cnt_o(spec_cnt), .zero_o(spec_zero), .err_o(spec_bad)
  );

  l2rc_bank #(.NREG(NUM_REGS), .LIMIT(NUM_REGS), .CW(RT_CW),
              .NI(1), .ND(1)) u_ret (
    .clk(clk), .rst_n(rst_ni), .clr(1'b0),
    .inc_vld(ret_hit && ren_new_vld), .inc_idx(ren_new_idx),
    .dec_vld(ret_hit && ren_old_vld), .dec_idx(ren_old_idx),
    .cnt_o(ret_cnt), .zero_o(ret_zero), .err_o(ret_bad)
  );

  // free search over committed state only
  logic [NUM_REGS-1:0] avail;
  logic                found;
  logic [IW-1:0]       pick_idx;
  assign avail = rob_zero & spec_zero & ret_zero;

  l2rc_pick #(.NREG(NUM_REGS)) u_pick (
    .avail(avail), .found(found), .idx(pick_idx)
  );

  assign alloc_gnt = alloc_req && found;
  assign alloc_idx = alloc_gnt ? pick_idx : '0;

  // sticky error
  logic err_q, err_d, err_en;
  always_comb begin
    err_d  = err_q | rob_bad | spec_bad | ret_bad;
    err_en = (err_d != err_q);
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end
  assign err = err_q;
endmodule

// File: rtl/l2rc_chk.sv
module l2rc_chk #(
  parameter int NUM_REGS = 8,
  parameter int RT_CW    = 5,
  parameter int ROB_CW   = 5,
  parameter int LANES    = 2,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input logic                       clk,
  input logic                       rst_ni,
  input logic                       alloc_req,
  input logic                       alloc_gnt,
  input logic [IW-1:0]              alloc_idx,
  input logic                       ren_vld,
  input logic                       ren_sel,
  input logic [LANES-1:0]           push_vld,
  input logic [LANES-1:0]           pop_vld,
  input logic                       flush,
  input logic                       err,
  input logic [NUM_REGS*ROB_CW-1:0] rob_cnt,
  input logic [NUM_REGS*RT_CW-1:0]  spec_cnt,
  input logic [NUM_REGS*RT_CW-1:0]  ret_cnt
);
  logic [NUM_REGS-1:0] fr;
  int                  low;
  always_comb begin
    low = 0;
    for (int i = 0; i < NUM_REGS; i++)
      fr[i] = (rob_cnt[i*ROB_CW +: ROB_CW] == '0) &&
              (spec_cnt[i*RT_CW +: RT_CW] == '0) &&
              (ret_cnt[i*RT_CW +: RT_CW] == '0);
    for (int i = NUM_REGS - 1; i >= 0; i--)
      if (fr[i]) low = i;
  end

  p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    alloc_gnt |-> fr[alloc_idx]);
  p_grant_lowest_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    alloc_gnt |-> (int'(alloc_idx) == low));
  p_grant_offered_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (alloc_req && (fr != '0)) |-> alloc_gnt);
  p_spec_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(ren_vld && !ren_sel) |=> (spec_cnt == $past(spec_cnt)));
  p_ret_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(ren_vld && ren_sel) |=> (ret_cnt == $past(ret_cnt)));
  p_rob_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!flush && (push_vld == '0) && (pop_vld == '0)) |=> $stable(rob_cnt));
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |=> (rob_cnt == '0));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    err |=> err);
endmodule

bind l2_refcount_alloc l2rc_chk #(
  .NUM_REGS(NUM_REGS), .RT_CW(RT_CW), .ROB_CW(ROB_CW), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_ni(rst_ni), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
  .alloc_idx(alloc_idx), .ren_vld(ren_vld), .ren_sel(ren_sel),
  .push_vld(push_vld), .pop_vld(pop_vld), .flush(flush), .err(err),
  .rob_cnt(rob_cnt), .spec_cnt(spec_cnt), .ret_cnt(ret_cnt)
);

// File: tb/tb_l2_refcount_alloc.sv
module tb_l2_refcount_alloc;
  localparam int NR = 8;
  localparam int RD = 16;
  localparam int LN = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, alloc_req, alloc_gnt, ren_vld, ren_sel, ren_old_vld, ren_new_vld, flush, err;
  logic [IW-1:0] alloc_idx, ren_old_idx, ren_new_idx;
  logic [LN-1:0] push_vld, pop_vld;
  logic [LN*IW-1:0] push_idx, pop_idx;

  l2_refcount_alloc #(.NUM_REGS(NR), .RT_SLOTS(16), .ROB_DEPTH(RD), .LANES(LN)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
    .alloc_idx(alloc_idx), .ren_vld(ren_vld), .ren_sel(ren_sel),
    .ren_old_vld(ren_old_vld), .ren_old_idx(ren_old_idx),
    .ren_new_vld(ren_new_vld), .ren_new_idx(ren_new_idx),
    .push_vld(push_vld), .push_idx(push_idx), .pop_vld(pop_vld), .pop_idx(pop_idx),
    .flush(flush), .err(err)
  );

  int total = 0;
  int bad = 0;
  int m_rob[NR];
  int m_spec[NR];
  int m_ret[NR];
  bit m_err;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    ren_vld = 0; ren_sel = 0; ren_old_vld = 0; ren_old_idx = 0;
    ren_new_vld = 0; ren_new_idx = 0; push_vld = 0; push_idx = 0;
    pop_vld = 0; pop_idx = 0; flush = 0;
  endtask

  function automatic int upd(input int cur, input int d, input int lim);
    if ((cur + d < 0) || (cur + d > lim)) begin
      m_err = 1;
      return cur;
    end
    return cur + d;
  endfunction

  task automatic model_apply();
    for (int r = 0; r < NR; r++) begin
      int ds, dr, dq;
      ds = 0; dr = 0; dq = 0;
      if (ren_vld && ren_new_vld && ren_new_idx == r) begin
        if (ren_sel) dr++; else ds++;
      end
      if (ren_vld && ren_old_vld && ren_old_idx == r) begin
        if (ren_sel) dr--; else ds--;
      end
      for (int l = 0; l < LN; l++) begin
        if (push_vld[l] && push_idx[l*IW +: IW] == r) dq++;
        if (pop_vld[l] && pop_idx[l*IW +: IW] == r) dq--;
      end
      m_spec[r] = upd(m_spec[r], ds, NR);
      m_ret[r]  = upd(m_ret[r], dr, NR);
      if (flush) m_rob[r] = 0;
      else m_rob[r] = upd(m_rob[r], dq, RD);
    end
  endtask

  task automatic check_state(input string tag);
    int e;
    e = -1;
    for (int r = NR - 1; r >= 0; r--)
      if (m_rob[r] == 0 && m_spec[r] == 0 && m_ret[r] == 0) e = r;
    #1;
    chk({tag, " gnt"}, int'(alloc_gnt), (alloc_req && e >= 0) ? 1 : 0);
    chk({tag, " idx"}, int'(alloc_idx), (alloc_req && e >= 0) ? e : 0);
    chk({tag, " err"}, int'(err), int'(m_err));
  endtask

  task automatic step(input string tag);
    model_apply();
    @(posedge clk); #2;
    idle();
    check_state(tag);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    for (int r = 0; r < NR; r++) begin m_rob[r] = 0; m_spec[r] = 0; m_ret[r] = 0; end
    m_err = 0;
  endtask

  task automatic ren(input bit sel, input bit ov, input int oi, input bit nv, input int ni);
    ren_vld = 1; ren_sel = sel; ren_old_vld = ov; ren_old_idx = IW'(oi);
    ren_new_vld = nv; ren_new_idx = IW'(ni);
  endtask

  task automatic t_reset();
    check_state("R1 reset");
    chk("R1 idx0", int'(alloc_idx), 0);
    alloc_req = 0; #1;
    chk("R2 no request", int'(alloc_gnt), 0);
    alloc_req = 1;
  endtask

  task automatic t_rename();
    ren(0, 0, 0, 1, 0); step("R3 spec new0");
    chk("R3 idx1", int'(alloc_idx), 1);
    ren(1, 0, 0, 1, 1); step("R3 ret new1");
    chk("R3 idx2", int'(alloc_idx), 2);
    ren(0, 1, 0, 1, 2); step("R3 spec replace 0->2");
    chk("R3 idx0 freed", int'(alloc_idx), 0);
    push_vld = 2'b01; push_idx = 6'(0); step("R5 push0");
    ren(1, 1, 1, 0, 0); step("R3 ret release1");
    chk("R3 idx1 freed", int'(alloc_idx), 1);
  endtask

  task automatic t_same();
    ren(0, 1, 2, 1, 2); step("R4 same reg");
    chk("R4 no err", int'(err), 0);
    ren(1, 1, 6, 1, 6); step("R4 same reg at zero");
    chk("R4 no err at zero", int'(err), 0);
  endtask

  task automatic t_lanes();
    push_vld = 2'b11; push_idx = {3'd1, 3'd1}; step("R5 two lanes same reg");
    pop_vld = 2'b01; pop_idx = {3'd0, 3'd1}; step("R6 pop one lane");
    chk("R6 reg1 still held", int'(alloc_idx), 3);
    push_vld = 2'b01; push_idx = {3'd0, 3'd3};
    pop_vld = 2'b10; pop_idx = {3'd3, 3'd0}; step("R11 push+pop same reg");
    chk("R11 no err", int'(err), 0);
    chk("R11 reg3 free", int'(alloc_idx), 3);
    pop_vld = 2'b11; pop_idx = {3'd1, 3'd0}; step("R6 pop two regs");
  endtask

  task automatic t_flush();
    push_vld = 2'b11; push_idx = {3'd5, 3'd4}; step("R5 push 4,5");
    flush = 1; push_vld = 2'b01; push_idx = {3'd0, 3'd3}; step("R7 flush with push");
    chk("R7 rob cleared, spec kept", int'(alloc_idx), 0);
    ren(0, 0, 0, 1, 0); step("R7 take0");
    ren(0, 0, 0, 1, 1); step("R7 take1");
    chk("R7 spec reg2 kept, push dropped", int'(alloc_idx), 3);
  endtask

  task automatic t_comb();
    ren(0, 0, 0, 1, 3); #1;
    chk("R12 idx before edge", int'(alloc_idx), 3);
    step("R12 after edge");
    chk("R12 idx after edge", int'(alloc_idx), 4);
  endtask

  task automatic t_underflow();
    do_reset();
    pop_vld = 2'b01; pop_idx = 6'(6); step("R8 pop at zero");
    chk("R8 err", int'(err), 1);
    repeat (3) @(posedge clk);
    #2 check_state("R10 err held");
    chk("R10 err sticky", int'(err), 1);
    do_reset();
    check_state("R10 reset clears");
    ren(0, 1, 5, 0, 0); step("R8 spec release at zero");
    chk("R8 idx unchanged", int'(alloc_idx), 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 5; i++) begin ren(1, 0, 0, 1, i); step("R3 fill ret"); end
    for (int i = 0; i < NR; i++) begin ren(0, 0, 0, 1, 5); step("R9 spec up"); end
    chk("R9 no err at limit", int'(err), 0);
    ren(0, 0, 0, 1, 5); step("R9 spec over limit");
    chk("R9 err", int'(err), 1);
    for (int i = 0; i < NR - 1; i++) begin ren(0, 1, 5, 0, 0); step("R9 spec down"); end
    chk("R9 still held", int'(alloc_idx), 6);
    ren(0, 1, 5, 0, 0); step("R9 last release");
    chk("R9 held not wrapped", int'(alloc_idx), 5);
    do_reset();
    for (int i = 0; i < RD / 2; i++) begin
      push_vld = 2'b11; push_idx = 6'(0); step("R9 rob up");
    end
    chk("R9 rob no err at depth", int'(err), 0);
    push_vld = 2'b11; push_idx = 6'(0); step("R9 rob over depth");
    chk("R9 rob err", int'(err), 1);
    for (int i = 0; i < RD / 2; i++) begin
      pop_vld = 2'b11; pop_idx = 6'(0); step("R9 rob down");
    end
    chk("R9 rob freed", int'(alloc_idx), 0);
  endtask

  initial begin
    alloc_req = 1;
    do_reset();
    t_reset();
    t_rename();
    t_same();
    t_lanes();
    t_flush();
    t_comb();
    t_underflow();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule